// File: doc/BRIEF.md
# Reset Pulse Sleep Sequencer

This block watches an active-low run/reset command line and tells two commands apart by how long the line stays low. A brief low pulse asks for the latched faults to be cleared, and the device keeps running. A low level held for a set number of clock cycles or more sends the device to sleep. Sleep clears the faults, and the sleep output is used to switch off the regulator and the internal circuitry.

Gate drive is forced off for as long as the command line is low. When the line returns high after a sleep, the block holds gate drive off for a startup interval. It releases gate drive only when that minimum wake delay has passed and the charge-pump-ready input is also high. Power-on reset is handled as a wake. The command line is asynchronous and passes through a synchronizer first. The fault-clear output is a single-cycle strobe, meant for the fault latches outside this block.

Top module: `pulse_sleep_seq`

## Requirements
- R1: During reset and in the first cycle after reset, `sleepOut`, `gateEn` and `faultClr` are all 0.
- R2: A low pulse on `runN` shorter than `LONG_CYC` clock cycles produces exactly one `faultClr` cycle. That cycle comes three clock cycles after `runN` returns high. `sleepOut` stays 0.
- R3: A low level on `runN` lasting `LONG_CYC` cycles or longer sets `sleepOut` to 1 two cycles after the `LONG_CYC`-th low cycle. `faultClr` pulses for one cycle in that same cycle.
- R4: `gateEn` goes to 0 within two cycles of `runN` going low and stays 0 while the synchronized line is low.
- R5: In sleep, a rising edge on `runN` clears `sleepOut` three cycles after the edge.
- R6: After a wake, `gateEn` stays 0 for at least `WAKE_CYC` cycles.
- R7: After a wake, `gateEn` stays 0 while `cpReady` is 0, even once the wake delay has passed. It goes to 1 one cycle after `cpReady` is seen high.
- R8: Releasing `runN` after a sleep produces no `faultClr` pulse.
- R9: A short low pulse during the wake interval pulses `faultClr` but does not enter sleep, and it does not release `gateEn` early.
- R10: `sleepOut` and `gateEn` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| runN | input | 1 | Asynchronous active-low run/reset command line |
| cpReady | input | 1 | Charge pump at operating level (synchronous) |
| faultClr | output | 1 | One-cycle strobe that clears latched faults |
| sleepOut | output | 1 | Device asleep; regulator and internal circuitry off |
| gateEn | output | 1 | Gate drive allowed |

## Verification
The bench aims at the pulse-width boundary. A low pulse of `LONG_CYC-1` cycles must clear faults only. A pulse of exactly `LONG_CYC` cycles must sleep; a design with an off-by-one threshold would sleep on the first or clear on the second. The bench also releases a long pulse and expects no fault-clear strobe, catching a design that treats every rising edge as a clear request. During wake it holds `cpReady` low past the delay and sends a short pulse mid-wake, so gate drive released on the timer alone or on any rising edge shows up as an early `gateEn`.

// File: rtl/pss_pkg.sv
package pss_pkg;
  typedef enum logic [1:0] {
    ST_WAKE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_SLEEP = 2'd2
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic wakeClr;  // zero the wake timer
    logic wakeRun;  // advance the wake timer
  } wakeCtl_t;
endpackage

// File: rtl/pss_datapath.sv
module pss_datapath
  import pss_pkg::*;
#(
  parameter int LONG_CYC    = 1000,
  parameter int WAKE_CYC    = 3000,
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     runN,
  input  wakeCtl_t ctl,
  output logic     runSync,
  output logic     rise,
  output logic     sleepHit,
  output logic     wakeDone
);
  localparam int LW = $clog2(LONG_CYC + 1);
  localparam int WW = $clog2(WAKE_CYC + 1);
  localparam logic [LW-1:0] LOW_SAT  = LW'(LONG_CYC);
  localparam logic [LW-1:0] LOW_LAST = LW'(LONG_CYC - 1);
  localparam logic [WW-1:0] WAKE_END = WW'(WAKE_CYC);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevSync;
  logic [LW-1:0]          lowCnt;
  logic [WW-1:0]          wakeCnt;

  // synchronizer chain, idles high (line released)
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) syncQ <= '1;
        else        syncQ <= runN;
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) syncQ <= '1;
        else        syncQ <= {syncQ[SYNC_STAGES-2:0], runN};
      end
    end
  endgenerate

  assign runSync = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prevSync <= 1'b1;
    else        prevSync <= runSync;
  end

  assign rise = runSync & ~prevSync;

  // low-time counter, saturates so the sleep strobe fires once per pulse
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              lowCnt <= '0;
    else if (runSync)        lowCnt <= '0;
    else if (lowCnt != LOW_SAT) lowCnt <= lowCnt + 1'b1;
  end

  assign sleepHit = ~runSync & (lowCnt == LOW_LAST);

  // wake timer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                 wakeCnt <= '0;
    else if (ctl.wakeClr)                       wakeCnt <= '0;
    else if (ctl.wakeRun && wakeCnt != WAKE_END) wakeCnt <= wakeCnt + 1'b1;
  end

  assign wakeDone = (wakeCnt == WAKE_END);
endmodule

// File: rtl/pss_ctrl.sv
module pss_ctrl
  import pss_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     runSync,
  input  logic     rise,
  input  logic     sleepHit,
  input  logic     wakeDone,
  input  logic     cpReady,
  output wakeCtl_t ctl,
  output logic     faultClr,
  output logic     sleepOut,
  output logic     gateEn
);
  seqState_t state, stateNxt;

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_SLEEP: if (rise) stateNxt = ST_WAKE;
      ST_WAKE: begin
        if (sleepHit)                 stateNxt = ST_SLEEP;
        else if (wakeDone && cpReady) stateNxt = ST_RUN;
      end
      ST_RUN:  if (sleepHit) stateNxt = ST_SLEEP;
      default: stateNxt = ST_SLEEP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_WAKE;
    else        state <= stateNxt;
  end

  // clear on a short pulse's release or on sleep entry, never on wake
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) faultClr <= 1'b0;
    else        faultClr <= (state != ST_SLEEP) && (rise || sleepHit);
  end

  assign ctl.wakeClr = (state == ST_SLEEP);
  assign ctl.wakeRun = (state == ST_WAKE);
  assign sleepOut    = (state == ST_SLEEP);
  assign gateEn      = (state == ST_RUN) && runSync;
endmodule

// File: rtl/pulse_sleep_seq.sv
module pulse_sleep_seq
  import pss_pkg::*;
#(
  parameter int LONG_CYC    = 1000,
  parameter int WAKE_CYC    = 3000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic runN,
  input  logic cpReady,
  output logic faultClr,
  output logic sleepOut,
  output logic gateEn
);
  wakeCtl_t ctl;
  logic     runSync, rise, sleepHit, wakeDone;

  pss_datapath #(
    .LONG_CYC(LONG_CYC), .WAKE_CYC(WAKE_CYC), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .runN(runN), .ctl(ctl),
    .runSync(runSync), .rise(rise), .sleepHit(sleepHit), .wakeDone(wakeDone)
  );

  pss_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .runSync(runSync), .rise(rise),
    .sleepHit(sleepHit), .wakeDone(wakeDone), .cpReady(cpReady),
    .ctl(ctl), .faultClr(faultClr), .sleepOut(sleepOut), .gateEn(gateEn)
  );
endmodule

// File: rtl/pss_checker.sv
module pss_checker #(
  parameter int WAKE_CYC = 3000
) (
  input logic clk,
  input logic rst_n,
  input logic runSync,
  input logic faultClr,
  input logic sleepOut,
  input logic gateEn
);
  localparam int CW = $clog2(WAKE_CYC + 2);
  localparam logic [CW-1:0] CSAT = CW'(WAKE_CYC + 1);

  // cycles since leaving sleep (or reset), saturating
  logic [CW-1:0] sinceWake;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 sinceWake <= '0;
    else if (sleepOut)          sinceWake <= '0;
    else if (sinceWake != CSAT) sinceWake <= sinceWake + 1'b1;
  end

  assert_one_cycle_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    faultClr |=> !faultClr);

  assert_clear_on_sleep_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleepOut) |-> faultClr);

  assert_gate_off_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !runSync |-> !gateEn);

  assert_wake_delay_R6: assert property (@(posedge clk) disable iff (!rst_n)
    gateEn |-> (sinceWake > CW'(WAKE_CYC)));

  assert_no_clear_on_wake_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleepOut) |-> !faultClr);

  assert_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(sleepOut && gateEn));
endmodule

bind pulse_sleep_seq pss_checker #(.WAKE_CYC(WAKE_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .runSync(runSync), .faultClr(faultClr),
  .sleepOut(sleepOut), .gateEn(gateEn)
);

// File: tb/tb_pulse_sleep_seq.sv
module tb_pulse_sleep_seq;
  localparam int CLK_PERIOD = 10;
  localparam int L  = 16;
  localparam int WK = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic runN = 1'b1;
  logic cpReady = 1'b0;
  logic faultClr, sleepOut, gateEn;

  int cyc = 0;
  int nChecks = 0;
  int nFail = 0;
  int expQ[$];
  bit finished = 1'b0;

  pulse_sleep_seq #(.LONG_CYC(L), .WAKE_CYC(WK), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .runN(runN), .cpReady(cpReady),
    .faultClr(faultClr), .sleepOut(sleepOut), .gateEn(gateEn)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // driver: low pulse of w cycles, pushing the expected clear-strobe cycle
  task automatic pulse(input int w);
    int c0;
    c0 = cyc;
    runN = 1'b0;
    if (w >= L) expQ.push_back(c0 + L + 2);   // R3 sleep-entry strobe
    else        expQ.push_back(c0 + w + 3);   // R2 short-pulse strobe
    repeat (w) @(negedge clk);
    runN = 1'b1;
  endtask

  // monitor: every strobe must match the front of the queue
  always @(negedge clk) begin
    if (rst_n && faultClr) begin
      if (expQ.size() == 0) chk(1'b0, "R2/R8 unexpected faultClr", cyc, -1);
      else begin
        int e;
        e = expQ.pop_front();
        chk(cyc == e, "R2/R3 faultClr cycle", cyc, e);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      chk(1'b0, "watchdog", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(sleepOut == 0 && gateEn == 0 && faultClr == 0, "R1 in reset", {sleepOut, gateEn, faultClr}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sleepOut == 0 && gateEn == 0 && faultClr == 0, "R1 after reset", {sleepOut, gateEn, faultClr}, 0);

    // power-on wake: gate off until delay and ready
    cpReady = 1'b1;
    repeat (10) @(negedge clk);
    chk(gateEn == 0, "R6 gate off early in wake", gateEn, 0);
    repeat (WK) @(negedge clk);
    chk(gateEn == 1, "R6 gate on after delay", gateEn, 1);

    // short pulse while running
    fork
      pulse(5);
      begin repeat (3) @(negedge clk); chk(gateEn == 0, "R4 gate off while low", gateEn, 0); end
    join
    repeat (6) @(negedge clk);
    chk(sleepOut == 0, "R2 stays awake", sleepOut, 0);
    chk(gateEn == 1, "R2 gate back on", gateEn, 1);

    // boundary: one cycle short of the threshold
    pulse(L - 1);
    repeat (6) @(negedge clk);
    chk(sleepOut == 0, "R2 boundary L-1 no sleep", sleepOut, 0);

    // boundary: exactly the threshold
    cpReady = 1'b0;
    pulse(L);
    repeat (2) @(negedge clk);
    chk(sleepOut == 1, "R3 boundary L sleeps", sleepOut, 1);
    repeat (3) @(negedge clk);
    chk(sleepOut == 0, "R5 woke after release", sleepOut, 0);
    repeat (WK + 10) @(negedge clk);
    chk(gateEn == 0, "R7 gate off without cpReady", gateEn, 0);
    cpReady = 1'b1;
    repeat (2) @(negedge clk);
    chk(gateEn == 1, "R7 gate on after cpReady", gateEn, 1);

    // long hold, then release: no strobe on wake
    pulse(L + 20);
    chk(sleepOut == 1, "R3 asleep during long low", sleepOut, 1);
    chk(gateEn == 0, "R4 gate off in sleep", gateEn, 0);
    repeat (3) @(negedge clk);
    chk(sleepOut == 0, "R5 sleep cleared", sleepOut, 0);
    repeat (8) @(negedge clk);
    chk(expQ.size() == 0, "R8 no strobe on wake", expQ.size(), 0);

    // short pulse during wake
    pulse(3);
    repeat (6) @(negedge clk);
    chk(sleepOut == 0, "R9 no sleep from wake pulse", sleepOut, 0);
    chk(gateEn == 0, "R9 gate still off in wake", gateEn, 0);
    repeat (WK) @(negedge clk);
    chk(gateEn == 1, "R9 gate on after wake", gateEn, 1);
    chk(!(gateEn && sleepOut), "R10 exclusive", {sleepOut, gateEn}, 2);

    repeat (5) @(negedge clk);
    chk(expQ.size() == 0, "R2 all strobes seen", expQ.size(), 0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule